// File: doc/BRIEF.md
# Serial Two-Wire Byte Memory Target

This block is an I2C target that fronts a 128-byte memory built from registers. A controller addresses it with a control byte that carries a fixed seven-bit device identity and a direction bit. A write transaction supplies a word address and then any number of data bytes. A read transaction returns bytes starting at the internal pointer. A read can follow a complete write, or it can follow an address-only write that is cut short by a repeated Start.

One address pointer serves every access. After a read, the pointer holds the address of the byte just returned plus one, and it wraps across the whole array. After a write, the pointer advances inside an 8-byte page, so a burst that runs past the page's last byte continues at the first byte of the same page.

The clock (SCL) and data (SDA) lines are synchronized to the system clock by two flip-flops each. SDA is presented as an input line, an output-enable and an output value. The pad is expected to be open-drain, so a driven 1 behaves like a released line.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A control byte whose upper seven bits are 1010111 is acknowledged. Bit 0 selects the direction: 1 is read and 0 is write. Any other control byte is not acknowledged, and the target then ignores every bit until the next Start, so later bytes are neither acknowledged nor stored.
- R2: In a write, the byte after the control byte loads the pointer with the word address. Each following data byte is stored at the pointer. Every one of these bytes is acknowledged.
- R3: After each stored byte, the low 3 pointer bits increment modulo 8 and the upper pointer bits stay fixed. A burst that stores the last byte of a page leaves the pointer at that page's first byte.
- R4: A read that has no address phase returns the byte at the pointer, which is the last accessed address plus one.
- R5: A write control byte and a word address, followed by a repeated Start and a read control byte, returns the byte at that word address. Afterwards the pointer addresses the next location.
- R6: In a multi-byte read, every controller ACK makes the target send the byte at the next address. The address goes from 127 back to 0.
- R7: Data bytes are sent MSB first. The target changes SDA only while SCL is low.
- R8: After a controller NACK and a Stop, and after any Start or Stop, the target does not drive SDA.
- R9: After reset the memory holds zeros, the pointer is 0 and SDA is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High while the target drives SDA |
| sda_o | output | 1 | Value placed on SDA while sda_oe is high |

## Verification
Each bus edge takes three system clocks to act: two synchronizer flops and one edge-history flop. The target therefore moves SDA three clocks after the SCL fall that calls for it. An acknowledge, or a data bit, is valid from that point until three clocks after the next SCL fall. The bench holds each SCL phase for ten clocks and samples SDA five clocks into the high phase. That point lies well after every change has settled and well before the next change can begin. Checks on SDA release are made one half-phase after the Stop completes. Stored contents are never read directly: they are confirmed through later bus reads, which the bench compares against a model computed from the address arithmetic.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_PRE,
        ST_ACK,
        ST_TX_PRE,
        ST_TX,
        ST_RACK
    } ee_state_e;

    typedef enum logic [1:0] {
        BY_CTRL,
        BY_ADDR,
        BY_DATA
    } ee_byte_e;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // [STAGES-1] is the synchronized value, [STAGES] the previous one
    logic [STAGES:0] scl_pipe_q;
    logic [STAGES:0] sda_pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-1:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe_q[STAGES-1];
    assign scl_old = scl_pipe_q[STAGES];
    assign sda_now = sda_pipe_q[STAGES-1];
    assign sda_old = sda_pipe_q[STAGES];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int         MEM_BYTES  = 128,
    parameter int         PAGE_BYTES = 8,
    parameter logic [6:0] DEV_ID     = 7'b1010111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic sda_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);
    localparam logic [PW-1:0] PG_ONE  = PW'(1);

    typedef struct packed {
        ee_state_e     st;
        ee_byte_e      kind;
        logic [2:0]    cnt;
        logic [7:0]    rx;
        logic [7:0]    tx;
        logic [AW-1:0] ptr;
        logic          rd;
    } regs_t;

    regs_t q, d;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          we;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata, rdata, rx_shift;

    i2c_ee_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ee_mem #(.DEPTH(MEM_BYTES)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (q.ptr),
        .rdata (rdata)
    );

    always_comb begin
        d        = q;
        we       = 1'b0;
        waddr    = q.ptr;
        rx_shift = {q.rx[6:0], sda_s};
        wdata    = rx_shift;
        if (stop_det) begin
            d.st = ST_IDLE;
        end else if (start_det) begin
            d.st   = ST_RX;
            d.kind = BY_CTRL;
            d.cnt  = 3'd0;
        end else begin
            unique case (q.st)
                ST_RX: if (scl_rise) begin
                    d.rx  = rx_shift;
                    d.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) begin
                        d.st = ST_ACK_PRE;
                        d.rd = 1'b0;
                        unique case (q.kind)
                            BY_CTRL: begin
                                if (rx_shift[7:1] == DEV_ID) begin
                                    d.kind = BY_ADDR;
                                    if (rx_shift[0]) begin
                                        d.rd  = 1'b1;
                                        d.tx  = rdata;
                                        d.ptr = q.ptr + PTR_ONE;
                                    end
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            BY_ADDR: begin
                                d.ptr  = rx_shift[AW-1:0];
                                d.kind = BY_DATA;
                            end
                            default: begin
                                we    = 1'b1;
                                d.ptr = {q.ptr[AW-1:PW], q.ptr[PW-1:0] + PG_ONE};
                            end
                        endcase
                    end
                end
                ST_ACK_PRE: if (scl_fall) d.st = ST_ACK;
                ST_ACK: if (scl_fall) begin
                    d.cnt = 3'd0;
                    d.st  = q.rd ? ST_TX : ST_RX;
                end
                ST_TX: if (scl_fall) begin
                    if (q.cnt == 3'd7) begin
                        d.st = ST_RACK;
                    end else begin
                        d.tx  = {q.tx[6:0], 1'b0};
                        d.cnt = q.cnt + 3'd1;
                    end
                end
                ST_RACK: if (scl_rise) begin
                    if (!sda_s) begin
                        d.tx  = rdata;
                        d.ptr = q.ptr + PTR_ONE;
                        d.st  = ST_TX_PRE;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                ST_TX_PRE: if (scl_fall) begin
                    d.cnt = 3'd0;
                    d.st  = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe = (q.st == ST_ACK) || (q.st == ST_TX);
    assign sda_o  = (q.st == ST_TX) ? q.tx[7] : 1'b0;

endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk #(
    parameter int AW = 7,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          sda_o,
    input logic          start_det,
    input logic          stop_det,
    input logic          we,
    input logic [AW-1:0] waddr,
    input logic [AW-1:0] ptr
);
    localparam logic [PW-1:0] PG1 = PW'(1);

    // R7: output enable moves only during the SCL low phase
    p_oe_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R7: a driven data value moves only during the SCL low phase
    p_data_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !$stable(sda_o)) |-> !scl_i);

    // R8: bus released after a Start
    p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R8: bus released after a Stop
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R3: a store leaves the pointer on the next byte of the same page
    p_page_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((ptr[AW-1:PW] == $past(waddr[AW-1:PW])) &&
                (ptr[PW-1:0] == ($past(waddr[PW-1:0]) + PG1))));

endmodule

bind i2c_eeprom_target i2c_ee_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o),
    .start_det (start_det),
    .stop_det  (stop_det),
    .we        (we),
    .waddr     (waddr),
    .ptr       (q.ptr)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int HQ = 5;
    localparam int NBYTES = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_line;
    logic sda_oe, sda_o;

    int total = 0;
    int bad = 0;
    logic [7:0] mem_m [NBYTES];
    int ptr_m = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_line = msda & ~(sda_oe & ~sda_o);

    i2c_eeprom_target uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .sda_o  (sda_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (HQ) @(negedge clk);
    endtask

    task automatic m_start();
        hw(); msda = 1'b1; hw(); scl = 1'b1; hw(); msda = 1'b0; hw(); scl = 1'b0;
    endtask

    task automatic m_stop();
        hw(); msda = 1'b0; hw(); scl = 1'b1; hw(); msda = 1'b1; hw();
    endtask

    task automatic m_bit(input logic b, output logic s);
        hw(); msda = b; hw(); scl = 1'b1; hw(); s = sda_line; hw(); scl = 1'b0;
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, s);
            b = {b[6:0], s};
        end
        m_bit(~give_ack, s);
    endtask

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 37 + 11 + seed * 91) & 255);
    endfunction

    // burst store of n bytes starting at a (R2, R3)
    task automatic page_write(input int a, input int n, input int seed);
        logic ack;
        int acks = 0;
        int p = a;
        m_start();
        m_wbyte(8'hAE, ack); acks += int'(ack);
        m_wbyte(8'(a), ack); acks += int'(ack);
        for (int k = 0; k < n; k++) begin
            m_wbyte(pat(p, seed), ack); acks += int'(ack);
            mem_m[p] = pat(p, seed);
            p = (p & ~7) | ((p + 1) & 7);
        end
        m_stop();
        ptr_m = p;
        check("R1/R2 write bytes acknowledged", acks, n + 2);
    endtask

    task automatic rand_read(input int a);
        logic ack;
        logic [7:0] b;
        m_start();
        m_wbyte(8'hAE, ack);
        m_wbyte(8'(a), ack);
        m_start();
        m_wbyte(8'hAF, ack);
        check("R1 read control acknowledged", int'(ack), 1);
        m_rbyte(1'b0, b);
        m_stop();
        check("R5/R7 random read data", int'(b), int'(mem_m[a]));
        ptr_m = (a + 1) % NBYTES;
    endtask

    task automatic cur_read(input string req);
        logic ack;
        logic [7:0] b;
        m_start();
        m_wbyte(8'hAF, ack);
        m_rbyte(1'b0, b);
        m_stop();
        check(req, int'(b), int'(mem_m[ptr_m]));
        check("R8 released after NACK and Stop", int'(sda_oe), 0);
        ptr_m = (ptr_m + 1) % NBYTES;
    endtask

    task automatic seq_read(input int n);
        logic ack;
        logic [7:0] b;
        int errs = 0;
        m_start();
        m_wbyte(8'hAF, ack);
        for (int k = 0; k < n; k++) begin
            m_rbyte(k != n - 1, b);
            if (b != mem_m[ptr_m]) begin
                errs++;
                $display("FAIL R6 sequential byte at %0h actual=%0h expected=%0h",
                         ptr_m, b, mem_m[ptr_m]);
            end
            ptr_m = (ptr_m + 1) % NBYTES;
        end
        m_stop();
        total++;
        if (errs != 0) bad++;
    endtask

    initial begin
        logic ack;
        for (int i = 0; i < NBYTES; i++) mem_m[i] = 8'h00;
        repeat (4) @(negedge clk);
        check("R9 no drive in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 no drive after reset", int'(sda_oe), 0);
        cur_read("R9 pointer and memory zero after reset");

        // R1: foreign identity, then bytes that would store if accepted
        m_start();
        m_wbyte(8'hA0, ack);
        check("R1 foreign control byte not acknowledged", int'(ack), 0);
        m_wbyte(8'h00, ack);
        check("R1 ignored until Start", int'(ack), 0);
        m_wbyte(8'hFF, ack);
        check("R1 ignored until Start", int'(ack), 0);
        m_stop();
        rand_read(0);

        // R2: fill the array one aligned page at a time
        for (int pg = 0; pg < NBYTES / 8; pg++) page_write(pg * 8, 8, 0);
        // R3: full page leaves pointer at first byte of the page
        cur_read("R3 pointer wrapped to page start");

        for (int a = 0; a < NBYTES; a += 5) begin
            rand_read(a);
            if (a % 25 == 0) cur_read("R4/R5 pointer after random read");
        end

        // R3: burst that crosses the page end
        page_write(8'h25, 5, 3);
        cur_read("R3 pointer inside page after wrap");
        rand_read(8'h20);
        rand_read(8'h27);
        page_write(8'h30, 8, 5);
        cur_read("R3 full page returns to first byte");

        // R6: sequential read across the top of the array
        rand_read(8'h7B);
        seq_read(6);
        cur_read("R4 pointer after sequential read");
        rand_read(8'h7F);
        seq_read(NBYTES + 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule